// File: doc/BRIEF.md
# Prescaled Interval Timer with Stop, Single-Shot and Auto-Reload Modes

This block is a general-purpose interval timer for a system-on-chip. Software programs it through a small register port: one control register, one prescale register and one divisor register. It also has a status register that holds a sticky expiry flag. The timer counts ticks from one of two sources. The internal source ticks once every two system clocks. The external source ticks on each rising edge of an asynchronous input, after that input is synchronized into the system clock domain. A prescale stage divides the source ticks by P+1, where P is the prescale value. A main counter then counts those divided ticks and expires after D+1 of them, where D is the divisor value. On each expiry the timer raises a one-cycle interrupt pulse and sets the sticky flag.

A state machine with four states controls the counting. `ST_IDLE` means stopped. `ST_RUN_ONCE` means counting toward a single expiry. `ST_RUN_FREE` means counting with automatic reload. `ST_HELD` means the single expiry has happened and the timer is waiting for a re-arm. The transitions are:

| Transition | From | To | Cause |
|---|---|---|---|
| start_once | any state | `ST_RUN_ONCE` | control write with the single-shot code |
| start_free | any state | `ST_RUN_FREE` | control write with the auto-reload code |
| halt | any state | `ST_IDLE` | control write with a stop code |
| expire_once | `ST_RUN_ONCE` | `ST_HELD` | the counter reaches its limit |
| expire_free | `ST_RUN_FREE` | `ST_RUN_FREE` | the counter reaches its limit and reloads |

Every start clears both counters and loads the prescale and divisor values. Those two values are loaded again at every reload.

Register addresses: 0 is control, 1 is prescale, 2 is divisor, 3 is status.

Top module: `pt_timer`

## Requirements
- R1: Control register bits [1:0] select the mode. 00 means stop, 01 means single-shot, 10 means auto-reload, and 11 also means stop. Control bit 2 selects the source: 0 for the internal half-rate tick, 1 for the external input.
- R2: With the internal source, the first interrupt pulse is high in the cycle that follows 2*(P+1)*(D+1) rising clock edges after the edge that samples the starting control write.
- R3: In single-shot mode exactly one pulse occurs. No further pulse occurs until the control register is written again with a running mode, which re-arms the timer with the same timing as R2.
- R4: In auto-reload mode, pulses repeat every 2*(P+1)*(D+1) cycles with no software action.
- R5: When the mode is 00 or 11, no interrupt pulse occurs. Writing either code stops a running timer.
- R6: With the external source, the input passes through a two-stage synchronizer and each rising edge counts as one source tick. A pulse follows every (P+1)*(D+1) rising edges.
- R7: The interrupt pulse output `irq_pulse` is exactly one clock cycle wide for each expiry.
- R8: Status bit 0 (address 3) is a sticky flag. It is set in the same cycle as each pulse and is cleared by any write to address 3. A new expiry wins over a clear in the same cycle.
- R9: A control write with a running mode restarts counting from zero, even while the timer is already running.
- R10: Prescale and divisor writes made while the timer runs do not change the period in progress. They take effect from the next reload.
- R11: With P=0 and D=0, the timer expires after a single source tick.
- R12: Reads return control in bits [2:0], prescale in bits [9:0] and divisor in bits [15:0]. Unused bits read zero, and all registers read zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 16 | Register read data, combinational |
| ext_clk | input | 1 | Asynchronous external count source |
| irq_pulse | output | 1 | One-cycle interrupt pulse on expiry |
| irq_flag | output | 1 | Sticky expiry flag |

## Verification
A wrong prescale or main count shows at the ports as a first pulse that comes early or late by a whole multiple of the source tick period. The bench checks this on the exact cycle of the first expiry.

A wrong state shows up differently depending on the mode:
- In single-shot mode, a state that fails to enter `ST_HELD` gives a second pulse one period later.
- A missed reload in auto-reload mode shows as a missing or misplaced pulse within one period.
- A reload that takes a new divisor too early shows as a shortened period right after the write.
- A restart that fails to clear the counters shows as a pulse earlier than a full period after the restart.

// File: rtl/pt_pkg.sv
package pt_pkg;

    typedef enum logic [1:0] {
        MODE_HALT     = 2'b00,
        MODE_ONCE     = 2'b01,
        MODE_FREE     = 2'b10,
        MODE_HALT_ALT = 2'b11
    } mode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN_ONCE,
        ST_RUN_FREE,
        ST_HELD
    } state_e;

    localparam logic [1:0] REG_CTL  = 2'd0;
    localparam logic [1:0] REG_PSC  = 2'd1;
    localparam logic [1:0] REG_DIV  = 2'd2;
    localparam logic [1:0] REG_STAT = 2'd3;

    localparam int CTL_W   = 3;
    localparam int SRC_BIT = 2;

endpackage

// File: rtl/pt_src_sel.sv
module pt_src_sel #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic running,
    input  logic use_ext,
    input  logic ext_clk,
    output logic src_tick
);
    localparam int CHAIN_W = SYNC_STAGES + 1;

    logic [CHAIN_W-1:0] chain_q;
    logic               half_q;
    logic               ext_edge;
    logic               int_tick;

    // synchronizer stages plus one history flop for edge detection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[CHAIN_W-2:0], ext_clk};
        end
    end

    assign ext_edge = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];

    // half-rate internal tick, phase-aligned at each start
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            half_q <= 1'b0;
        end else if (restart) begin
            half_q <= 1'b0;
        end else if (running) begin
            half_q <= ~half_q;
        end
    end

    assign int_tick = half_q;
    assign src_tick = use_ext ? ext_edge : int_tick;

endmodule

// File: rtl/pt_prescaler.sv
module pt_prescaler #(
    parameter int PSC_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             reload,
    input  logic             enable,
    input  logic             src_tick,
    input  logic [PSC_W-1:0] psc_cfg,
    output logic             cnt_tick
);
    logic [PSC_W-1:0] pcnt_q;
    logic [PSC_W-1:0] psc_act_q;

    assign cnt_tick = enable && src_tick && (pcnt_q == psc_act_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcnt_q    <= '0;
            psc_act_q <= '0;
        end else if (restart || reload) begin
            pcnt_q    <= '0;
            psc_act_q <= psc_cfg;
        end else if (enable && src_tick) begin
            if (cnt_tick) begin
                pcnt_q <= '0;
            end else begin
                pcnt_q <= pcnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/pt_core.sv
module pt_core
    import pt_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  mode_e            cmd_mode,
    input  logic             cnt_tick,
    input  logic [DIV_W-1:0] div_cfg,
    output logic             running,
    output logic             restart,
    output logic             reload,
    output logic             expire_evt,
    output logic             irq_pulse
);
    state_e           state_q;
    state_e           state_d;
    logic [DIV_W-1:0] mcnt_q;
    logic [DIV_W-1:0] div_act_q;
    logic             hit;
    logic             start_req;

    assign hit       = cnt_tick && (mcnt_q == div_act_q);
    assign start_req = cmd_valid && ((cmd_mode == MODE_ONCE) || (cmd_mode == MODE_FREE));

    // next-state logic: commands override, otherwise expiry transitions
    always_comb begin
        state_d = state_q;
        if (cmd_valid) begin
            unique case (cmd_mode)
                MODE_ONCE:     state_d = ST_RUN_ONCE;   // start_once
                MODE_FREE:     state_d = ST_RUN_FREE;   // start_free
                MODE_HALT,
                MODE_HALT_ALT: state_d = ST_IDLE;       // halt
            endcase
        end else begin
            unique case (state_q)
                ST_IDLE:     state_d = ST_IDLE;
                ST_RUN_ONCE: if (hit) state_d = ST_HELD; // expire_once
                ST_RUN_FREE: state_d = ST_RUN_FREE;       // expire_free reloads in place
                ST_HELD:     state_d = ST_HELD;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign running    = (state_q == ST_RUN_ONCE) || (state_q == ST_RUN_FREE);
    assign restart    = start_req;
    assign reload     = hit && (state_q == ST_RUN_FREE) && !cmd_valid;
    assign expire_evt = hit && !cmd_valid;

    // main count and active divisor
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mcnt_q    <= '0;
            div_act_q <= '0;
        end else if (start_req) begin
            mcnt_q    <= '0;
            div_act_q <= div_cfg;
        end else if (cmd_valid) begin
            mcnt_q <= '0;
        end else if (hit) begin
            mcnt_q <= '0;
            if (reload) begin
                div_act_q <= div_cfg;
            end
        end else if (cnt_tick) begin
            mcnt_q <= mcnt_q + 1'b1;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_pulse <= 1'b0;
        end else begin
            irq_pulse <= expire_evt;
        end
    end

endmodule

// File: rtl/pt_timer.sv
module pt_timer
    import pt_pkg::*;
#(
    parameter int PSC_W       = 10,
    parameter int DIV_W       = 16,
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              ext_clk,
    output logic              irq_pulse,
    output logic              irq_flag
);
    localparam int MODE_W = $bits(mode_e);

    logic [CTL_W-1:0] ctl_q;
    logic [PSC_W-1:0] psc_q;
    logic [DIV_W-1:0] div_q;
    logic             flag_q;

    logic  wr_ctl;
    logic  wr_psc;
    logic  wr_div;
    logic  wr_stat;
    mode_e cmd_mode;
    logic  running;
    logic  restart;
    logic  reload;
    logic  expire_evt;
    logic  src_tick;
    logic  cnt_tick;

    assign wr_ctl   = wr_en && (wr_addr == REG_CTL);
    assign wr_psc   = wr_en && (wr_addr == REG_PSC);
    assign wr_div   = wr_en && (wr_addr == REG_DIV);
    assign wr_stat  = wr_en && (wr_addr == REG_STAT);
    assign cmd_mode = mode_e'(wr_data[MODE_W-1:0]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
            psc_q <= '0;
            div_q <= '0;
        end else begin
            if (wr_ctl) ctl_q <= wr_data[CTL_W-1:0];
            if (wr_psc) psc_q <= wr_data[PSC_W-1:0];
            if (wr_div) div_q <= wr_data[DIV_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (expire_evt) begin
            flag_q <= 1'b1;
        end else if (wr_stat) begin
            flag_q <= 1'b0;
        end
    end

    assign irq_flag = flag_q;

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            REG_CTL:  rd_data[CTL_W-1:0] = ctl_q;
            REG_PSC:  rd_data[PSC_W-1:0] = psc_q;
            REG_DIV:  rd_data[DIV_W-1:0] = div_q;
            REG_STAT: rd_data[0]         = flag_q;
        endcase
    end

    pt_src_sel #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_src (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (restart),
        .running  (running),
        .use_ext  (ctl_q[SRC_BIT]),
        .ext_clk  (ext_clk),
        .src_tick (src_tick)
    );

    pt_prescaler #(
        .PSC_W (PSC_W)
    ) u_psc (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (restart),
        .reload   (reload),
        .enable   (running),
        .src_tick (src_tick),
        .psc_cfg  (psc_q),
        .cnt_tick (cnt_tick)
    );

    pt_core #(
        .DIV_W (DIV_W)
    ) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (wr_ctl),
        .cmd_mode   (cmd_mode),
        .cnt_tick   (cnt_tick),
        .div_cfg    (div_q),
        .running    (running),
        .restart    (restart),
        .reload     (reload),
        .expire_evt (expire_evt),
        .irq_pulse  (irq_pulse)
    );

endmodule

// File: rtl/pt_timer_chk.sv
module pt_timer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [1:0] wr_addr,
    input logic       irq_pulse,
    input logic       irq_flag,
    input logic [1:0] mode_q
);
    logic [1:0] once_cnt;
    logic       ctl_wr;
    logic       stat_wr;

    assign ctl_wr  = wr_en && (wr_addr == 2'd0);
    assign stat_wr = wr_en && (wr_addr == 2'd3);

    // pulses seen since the last control write, saturating
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            once_cnt <= '0;
        end else if (ctl_wr) begin
            once_cnt <= '0;
        end else if (irq_pulse && once_cnt != 2'd3) begin
            once_cnt <= once_cnt + 1'b1;
        end
    end

    p_once_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == 2'b01) |-> (once_cnt <= 2'd1));

    p_halt_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_q == 2'b00 || mode_q == 2'b11) && !ctl_wr) |=> !irq_pulse);

    p_pulse_narrow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |=> !irq_pulse);

    p_flag_on_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> irq_flag);

    p_flag_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stat_wr |=> (irq_flag == irq_pulse));

endmodule

bind pt_timer pt_timer_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .irq_pulse (irq_pulse),
    .irq_flag  (irq_flag),
    .mode_q    (ctl_q[1:0])
);

// File: tb/sim_pt_timer.sv
`timescale 1ns/1ps
module sim_pt_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic [1:0]  rd_addr = 2'd0;
    logic [15:0] rd_data;
    logic        ext_clk = 1'b0;
    logic        irq_pulse;
    logic        irq_flag;

    int errors = 0;
    int checks = 0;
    int n_irq  = 0;

    typedef struct packed {
        logic [1:0]  mode;
        logic [9:0]  psc;
        logic [15:0] dv;
        logic [15:0] exp_k;
    } vec_t;

    // exp_k = 2*(P+1)*(D+1)
    localparam vec_t VECS [0:4] = '{
        '{mode: 2'b01, psc: 10'd0, dv: 16'd0, exp_k: 16'd2},
        '{mode: 2'b10, psc: 10'd0, dv: 16'd3, exp_k: 16'd8},
        '{mode: 2'b01, psc: 10'd2, dv: 16'd1, exp_k: 16'd12},
        '{mode: 2'b10, psc: 10'd4, dv: 16'd4, exp_k: 16'd50},
        '{mode: 2'b10, psc: 10'd9, dv: 16'd2, exp_k: 16'd60}
    };

    always #4 clk = ~clk;

    pt_timer u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .ext_clk   (ext_clk),
        .irq_pulse (irq_pulse),
        .irq_flag  (irq_flag)
    );

    always @(negedge clk) if (rst_n && irq_pulse) n_irq++;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        @(negedge clk);
        rd_addr = a;
        #1;
        v = int'(rd_data);
    endtask

    task automatic wait_irq(input int limit, output int k);
        k = -1;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if (irq_pulse) begin
                k = i;
                break;
            end
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic ext_pulses(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); ext_clk = 1'b1;
            repeat (3) @(negedge clk);
            ext_clk = 1'b0;
            repeat (3) @(negedge clk);
        end
        #1;
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        int v;
        int k;
        int base;
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R12 reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            check(v == 0, "R12 reset read", v, 0);
        end
        check(irq_pulse == 1'b0 && irq_flag == 1'b0, "R12 reset outputs", int'({irq_pulse, irq_flag}), 0);

        // table walk: R1 R2 R3 R4 R7 R11
        foreach (VECS[i]) begin
            wr(2'd1, {6'd0, VECS[i].psc});
            wr(2'd2, VECS[i].dv);
            wr(2'd0, {14'd0, VECS[i].mode});
            wait_irq(2000, k);
            check(k == int'(VECS[i].exp_k), "R2 first expiry cycle", k, int'(VECS[i].exp_k));
            @(negedge clk);
            check(irq_pulse == 1'b0, "R7 pulse width", int'(irq_pulse), 0);
            if (VECS[i].mode == 2'b10) begin
                wait_irq(2000, k);
                check(k == int'(VECS[i].exp_k) - 2, "R4 reload period", k + 2, int'(VECS[i].exp_k));
            end else begin
                base = n_irq;
                idle(3 * int'(VECS[i].exp_k) + 20);
                check(n_irq == base, "R3 single shot stays silent", n_irq - base, 0);
                if (i == 0) begin
                    // R8 sticky flag then clear
                    rd(2'd3, v);
                    check(v == 1, "R8 flag set", v, 1);
                    wr(2'd3, 16'd0);
                    rd(2'd3, v);
                    check(v == 0 && irq_flag == 1'b0, "R8 flag cleared", v, 0);
                end
                // R3 re-arm
                wr(2'd0, {14'd0, VECS[i].mode});
                wait_irq(2000, k);
                check(k == int'(VECS[i].exp_k), "R3 rearm expiry", k, int'(VECS[i].exp_k));
            end
            wr(2'd0, 16'd0);
            idle(2);
        end
        check(VECS[0].exp_k == 16'd2, "R11 zero settings", int'(VECS[0].exp_k), 2);

        // R10: divisor change applies at next reload
        wr(2'd1, 16'd0);
        wr(2'd2, 16'd3);
        wr(2'd0, 16'd2);
        wait_irq(200, k);
        check(k == 8, "R10 base period", k, 8);
        wr(2'd2, 16'd7);
        wait_irq(200, k);
        check(k == 6, "R10 period in progress unchanged", k, 6);
        wait_irq(200, k);
        check(k == 15, "R10 new period after reload", k + 1, 16);

        // R9: restart clears counters
        idle(3);
        wr(2'd0, 16'd2);
        wait_irq(200, k);
        check(k == 16, "R9 restart full period", k, 16);

        // R5: stop codes 00 and 11
        wr(2'd0, 16'd0);
        base = n_irq;
        idle(100);
        check(n_irq == base, "R5 stop code 00 silent", n_irq - base, 0);
        wr(2'd0, 16'd2);
        wait_irq(200, k);
        wr(2'd0, 16'd3);
        base = n_irq;
        idle(100);
        check(n_irq == base, "R5 stop code 11 silent", n_irq - base, 0);

        // R6: external source, P=1 D=2 -> 6 edges per pulse
        wr(2'd1, 16'd1);
        wr(2'd2, 16'd2);
        wr(2'd0, 16'd6);
        base = n_irq;
        idle(40);
        check(n_irq == base, "R6 no internal ticks on external source", n_irq - base, 0);
        ext_pulses(12);
        check(n_irq - base == 2, "R6 twelve edges", n_irq - base, 2);
        ext_pulses(5);
        check(n_irq - base == 2, "R6 seventeen edges", n_irq - base, 2);
        ext_pulses(1);
        check(n_irq - base == 3, "R6 eighteen edges", n_irq - base, 3);

        // R12 / R1 readback
        wr(2'd0, 16'hFFFF);
        rd(2'd0, v);
        check(v == 7, "R12 control readback", v, 7);
        base = n_irq;
        ext_pulses(8);
        check(n_irq == base, "R1 mode 11 acts as stop", n_irq - base, 0);
        wr(2'd1, 16'hFFFF);
        rd(2'd1, v);
        check(v == 16'h03FF, "R12 prescale readback", v, 16'h03FF);
        wr(2'd2, 16'hABCD);
        rd(2'd2, v);
        check(v == 16'hABCD, "R12 divisor readback", v, 16'hABCD);

        summary();
        $finish;
    end

endmodule